// File: doc/BRIEF.md
# Over-Current Pulse-Skip and Latch Logic

This block sits between a per-cycle over-current comparator and the high-side gate logic of a buck converter. It never lets the high-side switch turn on in a clock where the comparator reports too much current. It also keeps track of how the current behaves after such an event. The first over-current seen on a switching-cycle strobe opens a skip period that lasts eight strobes. During that period, further over-current only suppresses pulses. A watch period of eight more strobes follows. Any over-current on a strobe inside the watch period shuts the converter down and holds it off.

If the watch period passes with no over-current, the tracker rearms itself. A later trip is then treated as a new first trip. A latched shutdown keeps the high side inhibited and holds a request that forces power-good low. Only dropping the enable input (or a reset) clears it. All windows are counted in switching-cycle strobes, not in system clocks. Windows and counts are parameters.

Top module: `oc_guard`

## Requirements
- R1: After reset, with `enable` high and `oc_flag` low, `latched_off`, `pg_low_req` and `hs_inhibit` are all 0.
- R2: In any clock where `enable` and `oc_flag` are both high, `hs_inhibit` is 1 in that same clock.
- R3: Only a clock with both `cyc_strobe` and `oc_flag` high counts as a trip or a window step. `oc_flag` without `cyc_strobe` has no effect on the windows or on the latch, and a strobe without a pending window has no effect either.
- R4: Counting the first-trip strobe as strobe 0, over-current on strobes 1 to 8 never sets `latched_off`.
- R5: Over-current on any strobe from 9 to 16 after the first trip sets `latched_off` from the next clock onward.
- R6: If strobes 9 to 16 all see no over-current, the tracker rearms after strobe 16. Over-current on strobe 17 or later is then a new first trip, and its own strobes 1 to 8 do not latch.
- R7: Once `latched_off` is 1 and `enable` stays high, `latched_off`, `pg_low_req` and `hs_inhibit` stay 1 whatever `cyc_strobe` and `oc_flag` do.
- R8: While `enable` is low, `hs_inhibit` and `pg_low_req` are 1, trips are ignored, and from the clock after `enable` falls `latched_off` is 0. After `enable` returns high the tracker starts idle (R1 outputs).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Converter enable; low clears the tracker and the latch |
| cyc_strobe | input | 1 | One-clock pulse per switching cycle, at the sampling point of the comparator |
| oc_flag | input | 1 | Over-current comparator result for the current cycle |
| hs_inhibit | output | 1 | High-side switch must not turn on |
| latched_off | output | 1 | Converter latched off by a repeat over-current |
| pg_low_req | output | 1 | Request to hold power-good low |

## Verification
The hardest conditions to reach are the two edges of the watch period. Over-current on strobe 8 must not latch, while over-current on strobe 9 or on strobe 16 must. A further case is the first strobe after a silent rearm, which must start a fresh sequence. Directed sequences place the comparator pulse on exactly those strobe indices. Idle clocks are placed between strobes so that pulses on non-strobe clocks fall inside an open window. A long pseudo-random run with sparse strobes, bursty over-current and rare enable drops then checks every clock against a strobe-index reference model.

// File: rtl/oc_guard_pkg.sv
package oc_guard_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SKIP  = 2'd1,
        ST_WATCH = 2'd2,
        ST_LATCH = 2'd3
    } oc_state_e;

    typedef struct packed {
        oc_state_e state;
    } oc_fsm_regs_t;

endpackage

// File: rtl/oc_window_ctr.sv
module oc_window_ctr #(
    parameter int SKIP_STROBES  = 8,
    parameter int WATCH_STROBES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic skip_last,
    output logic watch_last
);
    localparam int TOTAL = SKIP_STROBES + WATCH_STROBES;
    localparam int CNT_W = (TOTAL > 1) ? $clog2(TOTAL) : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctr_regs_t;

    ctr_regs_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (clr) begin
            ctr_d.cnt = '0;
        end else if (inc) begin
            ctr_d.cnt = ctr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctr_q <= '0;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign skip_last  = (ctr_q.cnt == CNT_W'(SKIP_STROBES - 1));
    assign watch_last = (ctr_q.cnt == CNT_W'(TOTAL - 1));

endmodule

// File: rtl/oc_guard_fsm.sv
module oc_guard_fsm
    import oc_guard_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      enable,
    input  logic      cyc_strobe,
    input  logic      oc_flag,
    input  logic      skip_last,
    input  logic      watch_last,
    output logic      cnt_clr,
    output logic      cnt_inc,
    output oc_state_e state_o
);
    oc_fsm_regs_t fsm_d, fsm_q;

    always_comb begin
        fsm_d   = fsm_q;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        if (!enable) begin
            fsm_d.state = ST_IDLE;
            cnt_clr     = 1'b1;
        end else if (cyc_strobe) begin
            unique case (fsm_q.state)
                ST_IDLE: begin
                    if (oc_flag) begin
                        fsm_d.state = ST_SKIP;
                        cnt_clr     = 1'b1;
                    end
                end
                ST_SKIP: begin
                    cnt_inc = 1'b1;
                    if (skip_last) begin
                        fsm_d.state = ST_WATCH;
                    end
                end
                ST_WATCH: begin
                    if (oc_flag) begin
                        fsm_d.state = ST_LATCH;
                    end else if (watch_last) begin
                        fsm_d.state = ST_IDLE;
                        cnt_clr     = 1'b1;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
                ST_LATCH: begin
                    fsm_d.state = ST_LATCH;
                end
                default: begin
                    fsm_d.state = ST_IDLE;
                    cnt_clr     = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q.state <= ST_IDLE;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign state_o = fsm_q.state;

endmodule

// File: rtl/oc_guard.sv
module oc_guard
    import oc_guard_pkg::*;
#(
    parameter int SKIP_STROBES  = 8,
    parameter int WATCH_STROBES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic cyc_strobe,
    input  logic oc_flag,
    output logic hs_inhibit,
    output logic latched_off,
    output logic pg_low_req
);
    logic      cnt_clr;
    logic      cnt_inc;
    logic      skip_last;
    logic      watch_last;
    oc_state_e state;

    oc_window_ctr #(
        .SKIP_STROBES (SKIP_STROBES),
        .WATCH_STROBES(WATCH_STROBES)
    ) ctr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (cnt_clr),
        .inc       (cnt_inc),
        .skip_last (skip_last),
        .watch_last(watch_last)
    );

    oc_guard_fsm fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .cyc_strobe(cyc_strobe),
        .oc_flag   (oc_flag),
        .skip_last (skip_last),
        .watch_last(watch_last),
        .cnt_clr   (cnt_clr),
        .cnt_inc   (cnt_inc),
        .state_o   (state)
    );

    assign latched_off = (state == ST_LATCH);
    assign pg_low_req  = !enable || latched_off;
    assign hs_inhibit  = !enable || latched_off || oc_flag;

endmodule

// File: rtl/oc_guard_chk.sv
module oc_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic cyc_strobe,
    input logic oc_flag,
    input logic hs_inhibit,
    input logic latched_off,
    input logic pg_low_req
);
    assert_inhibit_on_oc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && oc_flag) |-> hs_inhibit);

    assert_latch_needs_strobe_trip_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(latched_off) |-> ($past(cyc_strobe) && $past(oc_flag) && $past(enable)));

    assert_latch_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (latched_off && enable) |=> latched_off);

    assert_latch_outputs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        latched_off |-> (pg_low_req && hs_inhibit));

    assert_disable_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !latched_off);

    assert_disable_outputs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (hs_inhibit && pg_low_req));
endmodule

bind oc_guard oc_guard_chk chk_i (.*);

// File: tb/oc_guard_tb.sv
module oc_guard_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b1;
    logic cyc_strobe = 1'b0;
    logic oc_flag = 1'b0;
    logic hs_inhibit, latched_off, pg_low_req;

    int vectors = 0;
    int errors = 0;
    bit finished = 1'b0;

    // reference model: strobes since first trip (-1 when idle), latch flag
    int since = -1;
    bit m_lat = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    oc_guard dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cyc_strobe(cyc_strobe),
        .oc_flag(oc_flag), .hs_inhibit(hs_inhibit), .latched_off(latched_off),
        .pg_low_req(pg_low_req)
    );

    task automatic cmp(string tag, string sig, logic act, logic exp);
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, sig, act, exp, $time);
        end
    endtask

    task automatic tick(bit en, bit stb, bit oc, string tag);
        int idx;
        @(negedge clk);
        enable = en; cyc_strobe = stb; oc_flag = oc;
        #1;
        vectors++;
        cmp(tag, "latched_off", latched_off, m_lat);
        cmp(tag, "pg_low_req",  pg_low_req,  !en || m_lat);
        cmp(tag, "hs_inhibit",  hs_inhibit,  !en || m_lat || oc);
        // model update for the coming edge
        if (!en) begin
            since = -1; m_lat = 1'b0;
        end else if (stb && !m_lat) begin
            if (since < 0) begin
                if (oc) since = 0;
            end else begin
                idx = since + 1;
                if (idx >= 9 && oc) m_lat = 1'b1;
                else if (idx == 16) since = -1;
                else since = idx;
            end
        end
    endtask

    // strobe with one quiet clock after it
    task automatic strobe(bit oc, string tag);
        tick(1'b1, 1'b1, oc, tag);
        tick(1'b1, 1'b0, 1'b0, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        #1;
        vectors++;
        cmp("R1", "latched_off", latched_off, 1'b0);
        cmp("R1", "pg_low_req", pg_low_req, 1'b0);
        cmp("R1", "hs_inhibit", hs_inhibit, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (4) tick(1'b1, 1'b0, 1'b0, "R1");
        repeat (5) strobe(1'b0, "R3");

        // R2/R3: over-current without strobe: inhibit only, no arming
        repeat (6) tick(1'b1, 1'b0, 1'b1, "R2");
        repeat (20) strobe(1'b0, "R3");

        // R4/R5: trip, over-current on strobes 1..8 (8 is boundary), then 9 latches
        strobe(1'b1, "R4");
        for (int k = 1; k <= 8; k++) strobe(1'b1, "R4");
        strobe(1'b1, "R5");
        // R7: latched holds under any stimulus
        for (int k = 0; k < 10; k++) tick(1'b1, k[0], k[1], "R7");
        // R8: disable clears, ignores trips
        repeat (3) tick(1'b0, 1'b1, 1'b1, "R8");
        repeat (3) tick(1'b1, 1'b0, 1'b0, "R8");
        repeat (3) strobe(1'b0, "R8");

        // R5: over-current on strobe 16 latches
        strobe(1'b1, "R5");
        for (int k = 1; k <= 15; k++) strobe(1'b0, "R5");
        strobe(1'b1, "R5");
        tick(1'b0, 1'b0, 1'b0, "R8");

        // R3: inside watch, over-current on non-strobe clocks must not latch
        strobe(1'b1, "R3");
        for (int k = 1; k <= 10; k++) strobe(1'b0, "R3");
        repeat (4) tick(1'b1, 1'b0, 1'b1, "R3");
        for (int k = 11; k <= 16; k++) strobe(1'b0, "R3");

        // R6: silent watch rearms; strobe 17 is a fresh first trip
        strobe(1'b1, "R6");
        for (int k = 1; k <= 16; k++) strobe(1'b0, "R6");
        strobe(1'b1, "R6");
        for (int k = 1; k <= 8; k++) strobe(1'b1, "R6");
        strobe(1'b0, "R6");
        strobe(1'b1, "R6");
        tick(1'b0, 1'b0, 1'b0, "R8");

        // mixed pseudo-random traffic
        for (int i = 0; i < 6000; i++) begin
            bit en, stb, oc;
            en  = ($urandom_range(0, 299) != 0);
            stb = ($urandom_range(0, 2) == 0);
            oc  = ((i / 200) % 2 == 0) ? ($urandom_range(0, 19) == 0)
                                       : ($urandom_range(0, 3) == 0);
            tick(en, stb, oc, "R6");
        end

        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule